// File: doc/BRIEF.md
# Multiplexed Byte-Bus Slave Port

This block is the host-facing port of a clock/calendar device. It sits on a byte-wide bus where the same eight pins carry the address first and then the data. A pin chooses between two timing personalities on the same pins. In strobe-and-direction timing, DS marks the data phase and R/W gives the direction. In separate-enable timing, DS is an active-low output enable and R/W is an active-low write enable. A fast system clock samples every bus pin through a two-flop synchronizer, and edges are detected in the clock domain.

Behind the port is a simple register port with a 7-bit address, one-cycle read and write pulses, write data, and a combinational read-data return. The port covers a 128-byte space. The low fourteen locations are clock and control registers and the rest is general RAM.

The port enforces the read-only locations. Writes to the status and supply-check registers are dropped. The top bit of the seconds byte and of the first control register keeps its stored value on a write. Access is blocked while the bus reset pin is low or the power-fail input is high. When a read of the interrupt-status register ends, the port raises a one-cycle pulse so that flag-clear logic can act after the host has the data.

Top module: `mbus_port`

## Requirements
- R1: The address is the low 7 bits of the AD bus just before AS falls. A rising AS invalidates it, so a data strobe while AS is held high causes no access.
- R2: A data strobe taken with chip select inactive performs no access but still consumes the latched address. A later selected strobe without a new AS does nothing.
- R3: With the mode pin high and R/W high, a DS rise gives one read pulse. The port drives the read data (ad_oe_o=1) while DS stays high and stops driving after DS falls. ad_oe_o is 0 out of reset.
- R4: With the mode pin high, a DS fall with R/W low gives one write pulse. The pulse carries the latched address and the AD value present just before the fall.
- R5: With the mode pin low and R/W high, a DS fall gives one read pulse and drives the data. A DS rise ends the drive.
- R6: With the mode pin low and DS high, a rising R/W gives one write pulse with the AD value present just before that edge.
- R7: Writes to address 0x0C and 0x0D produce no write pulse.
- R8: A write to address 0x00 or 0x0A passes bit 7 of the current stored value and takes bits 6:0 from the bus.
- R9: While bus_rst_ni is low or pwr_fail_i is high, no read or write pulse occurs and the AD bus is not driven.
- R10: When a read window of address 0x0C ends, stat_rd_done_o pulses for one cycle in the cycle the drive stops.
- R11: Each address strobe allows at most one access. A second data strobe without a new AS does nothing.
- R12: If AS rises in the same sampled cycle as a write-ending DS fall, the write still takes place at the latched address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples all bus pins |
| rst_ni | input | 1 | Asynchronous active-low reset of the port logic |
| bus_rst_ni | input | 1 | Bus-side reset pin, active low; blocks access |
| pwr_fail_i | input | 1 | Supply below power-fail level; blocks access |
| mot_mode_i | input | 1 | 1: strobe-and-direction timing, 0: separate-enable timing |
| as_i | input | 1 | Address strobe |
| ds_i | input | 1 | Data strobe / output enable |
| rw_i | input | 1 | Direction / write enable |
| cs_ni | input | 1 | Chip select, active low |
| ad_i | input | 8 | AD bus input side |
| ad_o | output | 8 | AD bus output side |
| ad_oe_o | output | 1 | AD bus output enable |
| reg_rd_o | output | 1 | One-cycle read pulse to storage |
| reg_wr_o | output | 1 | One-cycle write pulse to storage |
| reg_addr_o | output | 7 | Latched access address |
| reg_wdata_o | output | 8 | Write data after read-only merge |
| reg_rdata_i | input | 8 | Stored byte at reg_addr_o |
| stat_rd_done_o | output | 1 | Pulse when a read of 0x0C ends |

## Verification
Two things can land in the same sampled cycle: the address-clearing rise of AS and the DS fall that commits a write. The bench provokes this by driving both pins in one step, so they cross the synchronizer together. It then expects the scoreboard to receive the write at the address latched earlier. A second case pairs a read-window end with the status-read pulse, and the bench counts that pulse against the reads of 0x0C it issued.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  parameter int ADDR_W = 7;
  parameter int DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_SEC  = 7'h00;
  localparam logic [ADDR_W-1:0] A_CTLA = 7'h0A;
  localparam logic [ADDR_W-1:0] A_STAT = 7'h0C;
  localparam logic [ADDR_W-1:0] A_SUPV = 7'h0D;

  function automatic logic wr_locked(input logic [ADDR_W-1:0] a);
    return (a == A_STAT) || (a == A_SUPV);
  endfunction

  function automatic logic [DATA_W-1:0] ro_bits(input logic [ADDR_W-1:0] a);
    return ((a == A_SEC) || (a == A_CTLA)) ? {1'b1, {(DATA_W-1){1'b0}}} : '0;
  endfunction
endpackage

// File: rtl/mbus_sync.sv
module mbus_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_VAL;
      else         stg_q[s] <= (s == 0) ? d_i : stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/mbus_strobe_dec.sv
module mbus_strobe_dec (
  input  logic mot_i,
  input  logic as_s_i, as_d_i,
  input  logic ds_s_i, ds_d_i,
  input  logic rw_s_i, rw_d_i,
  output logic as_fall_o,
  output logic as_rise_o,
  output logic rd_start_o,
  output logic rd_end_o,
  output logic wr_evt_o,
  output logic strobe_o
);
  logic ds_rise, ds_fall, rw_rise;

  assign ds_rise   = ds_s_i & ~ds_d_i;
  assign ds_fall   = ~ds_s_i & ds_d_i;
  assign rw_rise   = rw_s_i & ~rw_d_i;
  assign as_fall_o = ~as_s_i & as_d_i;
  assign as_rise_o = as_s_i & ~as_d_i;

  always_comb begin
    if (mot_i) begin
      rd_start_o = ds_rise & rw_s_i;
      rd_end_o   = ds_fall;
      wr_evt_o   = ds_fall & ~rw_d_i;
    end else begin
      rd_start_o = ds_fall & rw_s_i;
      rd_end_o   = ds_rise;
      wr_evt_o   = rw_rise & ds_s_i;
    end
  end

  // any data strobe consumes the latched address, selected or not
  assign strobe_o = rd_start_o | wr_evt_o;
endmodule

// File: rtl/mbus_wr_guard.sv
module mbus_wr_guard
  import mbus_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic [DATA_W-1:0] old_data_i,
  output logic              allow_o,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] keep;

  assign keep    = ro_bits(addr_i);
  assign allow_o = ~wr_locked(addr_i);
  assign data_o  = (bus_data_i & ~keep) | (old_data_i & keep);
endmodule

// File: rtl/mbus_port.sv
module mbus_port
  import mbus_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_rst_ni,
  input  logic              pwr_fail_i,
  input  logic              mot_mode_i,
  input  logic              as_i,
  input  logic              ds_i,
  input  logic              rw_i,
  input  logic              cs_ni,
  input  logic [DATA_W-1:0] ad_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic              reg_rd_o,
  output logic              reg_wr_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic [DATA_W-1:0] reg_rdata_i,
  output logic              stat_rd_done_o
);
  localparam int SYNC_W = DATA_W + 7;
  localparam logic [SYNC_W-1:0] SYNC_RST =
    {1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, {DATA_W{1'b0}}};

  logic [SYNC_W-1:0] sync_q;
  logic mot_s, brst_n_s, pf_s, cs_n_s, rw_s, ds_s, as_s;
  logic [DATA_W-1:0] ad_s;

  mbus_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({mot_mode_i, bus_rst_ni, pwr_fail_i, cs_ni, rw_i, ds_i, as_i, ad_i}),
    .q_o   (sync_q)
  );
  assign {mot_s, brst_n_s, pf_s, cs_n_s, rw_s, ds_s, as_s, ad_s} = sync_q;

  logic as_d, ds_d, rw_d;
  logic [DATA_W-1:0] ad_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      as_d <= 1'b0;
      ds_d <= 1'b0;
      rw_d <= 1'b1;
      ad_d <= '0;
    end else begin
      as_d <= as_s;
      ds_d <= ds_s;
      rw_d <= rw_s;
      ad_d <= ad_s;
    end
  end

  logic as_fall, as_rise, rd_start, rd_end, wr_evt, strobe;

  mbus_strobe_dec u_dec (
    .mot_i     (mot_s),
    .as_s_i    (as_s),  .as_d_i(as_d),
    .ds_s_i    (ds_s),  .ds_d_i(ds_d),
    .rw_s_i    (rw_s),  .rw_d_i(rw_d),
    .as_fall_o (as_fall),
    .as_rise_o (as_rise),
    .rd_start_o(rd_start),
    .rd_end_o  (rd_end),
    .wr_evt_o  (wr_evt),
    .strobe_o  (strobe)
  );

  logic cs_eff;
  assign cs_eff = ~cs_n_s & brst_n_s & ~pf_s;

  logic [ADDR_W-1:0] addr_q;
  logic              addr_vld_q;
  logic              wr_allow;
  logic [DATA_W-1:0] wr_data;

  mbus_wr_guard u_guard (
    .addr_i    (addr_q),
    .bus_data_i(ad_d),
    .old_data_i(reg_rdata_i),
    .allow_o   (wr_allow),
    .data_o    (wr_data)
  );

  logic              rd_act_q, rd_stat_q, rd_q, wr_q, done_q;
  logic [DATA_W-1:0] rdata_q, wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q     <= '0;
      addr_vld_q <= 1'b0;
      rd_act_q   <= 1'b0;
      rd_stat_q  <= 1'b0;
      rd_q       <= 1'b0;
      wr_q       <= 1'b0;
      done_q     <= 1'b0;
      rdata_q    <= '0;
      wdata_q    <= '0;
    end else begin
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
      done_q <= 1'b0;
      if (strobe)  addr_vld_q <= 1'b0;
      if (as_rise) addr_vld_q <= 1'b0;
      if (as_fall) begin
        addr_q     <= ad_d[ADDR_W-1:0];
        addr_vld_q <= 1'b1;
      end
      if (rd_start && addr_vld_q && cs_eff) begin
        rd_act_q  <= 1'b1;
        rd_q      <= 1'b1;
        rdata_q   <= reg_rdata_i;
        rd_stat_q <= (addr_q == A_STAT);
      end else if (rd_act_q && (rd_end || !cs_eff)) begin
        rd_act_q <= 1'b0;
        done_q   <= rd_stat_q;
      end
      if (wr_evt && addr_vld_q && cs_eff && wr_allow) begin
        wr_q    <= 1'b1;
        wdata_q <= wr_data;
      end
    end
  end

  assign ad_o           = rdata_q;
  assign ad_oe_o        = rd_act_q;
  assign reg_rd_o       = rd_q;
  assign reg_wr_o       = wr_q;
  assign reg_addr_o     = addr_q;
  assign reg_wdata_o    = wdata_q;
  assign stat_rd_done_o = done_q;

  a_r7_no_locked_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |-> !wr_locked(reg_addr_o));
  a_r8_keep_top_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_o && (reg_addr_o == A_SEC || reg_addr_o == A_CTLA))
      |-> reg_wdata_o[DATA_W-1] == reg_rdata_i[DATA_W-1]);
  a_r9_blocked_no_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!cs_eff) |-> !(reg_wr_o || reg_rd_o));
  a_r9_drive_needs_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ad_oe_o |-> $past(cs_eff));
  a_r11_single_read_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_o |=> !reg_rd_o);
  a_r11_rd_wr_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_rd_o && reg_wr_o));
  a_r10_done_at_window_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd_done_o |-> $fell(ad_oe_o));
endmodule

// File: tb/tb_mbus_port.sv
module tb_mbus_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_rst_n = 1'b1, pwr_fail = 1'b0, mot = 1'b1;
  logic as_p = 1'b0, ds = 1'b0, rw = 1'b1, cs_n = 1'b1;
  logic [7:0] ad = '0;
  logic [7:0] ad_o, reg_wdata, reg_rdata;
  logic       ad_oe, reg_rd, reg_wr, stat_done;
  logic [6:0] reg_addr;

  int checks = 0, failures = 0, rdc_cnt = 0;
  bit done = 0;
  logic [14:0] exp_q[$];
  logic [7:0]  mem [128];
  logic [7:0]  shd [128];

  always #4 clk = ~clk;

  mbus_port dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_rst_ni(bus_rst_n), .pwr_fail_i(pwr_fail),
    .mot_mode_i(mot), .as_i(as_p), .ds_i(ds), .rw_i(rw), .cs_ni(cs_n),
    .ad_i(ad), .ad_o(ad_o), .ad_oe_o(ad_oe), .reg_rd_o(reg_rd), .reg_wr_o(reg_wr),
    .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata), .reg_rdata_i(reg_rdata),
    .stat_rd_done_o(stat_done)
  );

  function automatic logic [7:0] init_val(input int i);
    return 8'(i * 37 + 11);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) for (int i = 0; i < 128; i++) mem[i] <= init_val(i);
    else if (reg_wr) mem[reg_addr] <= reg_wdata;
  end
  assign reg_rdata = mem[reg_addr];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && stat_done) rdc_cnt++;
    if (rst_n && reg_wr) begin
      if (exp_q.size() == 0) chk(1'b0, "R2/R7/R9/R11 unexpected write", {reg_addr, reg_wdata}, 0);
      else begin
        logic [14:0] e;
        e = exp_q.pop_front();
        chk({reg_addr, reg_wdata} === e, "R4/R6/R8 write content", {reg_addr, reg_wdata}, e);
      end
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic exp_write(input logic [6:0] a, input logic [7:0] d);
    logic [7:0] v;
    v = (a == 7'h00 || a == 7'h0A) ? {shd[a][7], d[6:0]} : d;
    shd[a] = v;
    exp_q.push_back({a, v});
  endtask

  task automatic addr_strobe(input logic [6:0] a);
    ad = {1'b0, a}; as_p = 1'b1; idle(4);
    as_p = 1'b0; idle(4);
  endtask

  task automatic mot_dstrobe_wr(input logic [7:0] d, input logic csn);
    ad = d; rw = 1'b0; cs_n = csn; idle(2);
    ds = 1'b1; idle(4); ds = 1'b0; idle(4);
    rw = 1'b1; cs_n = 1'b1; idle(2);
  endtask

  task automatic mot_write(input logic [6:0] a, input logic [7:0] d);
    addr_strobe(a); mot_dstrobe_wr(d, 1'b0);
  endtask

  task automatic mot_read(input logic [6:0] a, output logic seen, output logic [7:0] v);
    addr_strobe(a); rw = 1'b1; cs_n = 1'b0; idle(2);
    ds = 1'b1; seen = 1'b0; v = '0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (ad_oe) begin seen = 1'b1; v = ad_o; end
    end
    ds = 1'b0; idle(6); cs_n = 1'b1; idle(2);
  endtask

  task automatic intel_write(input logic [6:0] a, input logic [7:0] d);
    addr_strobe(a); ad = d; cs_n = 1'b0; rw = 1'b0; idle(4);
    rw = 1'b1; idle(6); cs_n = 1'b1; idle(2);
  endtask

  task automatic intel_read(input logic [6:0] a, output logic seen, output logic [7:0] v);
    addr_strobe(a); cs_n = 1'b0; idle(2);
    ds = 1'b0; seen = 1'b0; v = '0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (ad_oe) begin seen = 1'b1; v = ad_o; end
    end
    ds = 1'b1; idle(6); cs_n = 1'b1; idle(2);
  endtask

  initial begin
    logic seen;
    logic [7:0] v;
    int r0;
    for (int i = 0; i < 128; i++) shd[i] = init_val(i);
    idle(3);
    rst_n = 1'b1;
    idle(4);
    chk(ad_oe == 1'b0, "R3 reset no drive", ad_oe, 0);
    chk(reg_rd == 1'b0 && reg_wr == 1'b0, "R9 reset no pulses", {reg_rd, reg_wr}, 0);
    chk(stat_done == 1'b0, "R10 reset no done", stat_done, 0);

    // strobe-and-direction timing
    exp_write(7'h20, 8'hA5); mot_write(7'h20, 8'hA5);
    mot_read(7'h20, seen, v);
    chk(seen && v == shd[7'h20], "R3 read data", v, shd[7'h20]);
    chk(ad_oe == 1'b0, "R3 drive ends", ad_oe, 0);

    exp_write(7'h00, 8'hFF); mot_write(7'h00, 8'hFF);
    mot_read(7'h00, seen, v);
    chk(v == shd[7'h00], "R8 seconds top bit kept", v, shd[7'h00]);

    mot_write(7'h0C, 8'h55);
    r0 = rdc_cnt;
    mot_read(7'h0C, seen, v);
    chk(v == shd[7'h0C], "R7 status unchanged", v, shd[7'h0C]);
    chk(rdc_cnt == r0 + 1, "R10 status read done pulse", rdc_cnt, r0 + 1);
    r0 = rdc_cnt;
    mot_read(7'h21, seen, v);
    chk(rdc_cnt == r0, "R10 no pulse for other address", rdc_cnt, r0);

    // R2: unselected strobe consumes address
    addr_strobe(7'h22); mot_dstrobe_wr(8'h11, 1'b1); mot_dstrobe_wr(8'h12, 1'b0);
    mot_read(7'h22, seen, v);
    chk(v == shd[7'h22], "R2 consumed address no write", v, shd[7'h22]);

    // R11: second strobe without new AS
    exp_write(7'h23, 8'h44); addr_strobe(7'h23);
    mot_dstrobe_wr(8'h44, 1'b0); mot_dstrobe_wr(8'h99, 1'b0);
    mot_read(7'h23, seen, v);
    chk(v == shd[7'h23], "R11 one access per strobe", v, shd[7'h23]);

    // R1: strobe while AS high ignored; fall latches
    ad = 8'h25; as_p = 1'b1; idle(4);
    rw = 1'b0; cs_n = 1'b0; ad = 8'h25; ds = 1'b1; idle(4); ds = 1'b0; idle(4);
    as_p = 1'b0; idle(4);
    exp_write(7'h25, 8'h6B);
    ad = 8'h6B; ds = 1'b1; idle(4); ds = 1'b0; idle(4); rw = 1'b1; cs_n = 1'b1; idle(2);
    mot_read(7'h25, seen, v);
    chk(v == 8'h6B, "R1 address latched at fall", v, 8'h6B);

    // R12: AS rise together with write-ending DS fall
    exp_write(7'h26, 8'h3D); addr_strobe(7'h26);
    ad = 8'h3D; rw = 1'b0; cs_n = 1'b0; idle(2); ds = 1'b1; idle(4);
    ds = 1'b0; as_p = 1'b1; idle(4); as_p = 1'b0; idle(4); rw = 1'b1; cs_n = 1'b1; idle(2);
    mot_read(7'h26, seen, v);
    chk(v == 8'h3D, "R12 write kept with AS rise", v, 8'h3D);

    // R9: bus reset and power fail block access
    bus_rst_n = 1'b0; idle(2);
    mot_write(7'h27, 8'hEE); mot_read(7'h27, seen, v);
    chk(!seen, "R9 bus reset no drive", seen, 0);
    bus_rst_n = 1'b1; pwr_fail = 1'b1; idle(2);
    mot_write(7'h27, 8'hEF); mot_read(7'h27, seen, v);
    chk(!seen, "R9 power fail no drive", seen, 0);
    pwr_fail = 1'b0; idle(2);
    mot_read(7'h27, seen, v);
    chk(seen && v == shd[7'h27], "R9 location untouched", v, shd[7'h27]);

    // separate-enable timing
    mot = 1'b0; ds = 1'b1; idle(6);
    exp_write(7'h30, 8'h3C); intel_write(7'h30, 8'h3C);
    intel_read(7'h30, seen, v);
    chk(seen && v == 8'h3C, "R5/R6 read back", v, 8'h3C);
    chk(ad_oe == 1'b0, "R5 drive ends on DS rise", ad_oe, 0);
    exp_write(7'h0A, 8'hFF); intel_write(7'h0A, 8'hFF);
    intel_read(7'h0A, seen, v);
    chk(v == shd[7'h0A], "R8 control top bit kept", v, shd[7'h0A]);
    intel_write(7'h0D, 8'h00);
    intel_read(7'h0D, seen, v);
    chk(v == shd[7'h0D], "R7 supply register unchanged", v, shd[7'h0D]);
    r0 = rdc_cnt;
    intel_read(7'h0C, seen, v);
    chk(rdc_cnt == r0 + 1, "R10 status done separate-enable", rdc_cnt, r0 + 1);
    pwr_fail = 1'b1; idle(2);
    intel_write(7'h31, 8'h77); intel_read(7'h31, seen, v);
    chk(!seen, "R9 power fail separate-enable", seen, 0);
    pwr_fail = 1'b0; idle(2);
    intel_read(7'h31, seen, v);
    chk(v == shd[7'h31], "R9 separate-enable untouched", v, shd[7'h31]);

    idle(10);
    chk(exp_q.size() == 0, "R4/R6 all expected writes seen", exp_q.size(), 0);
    done = 1;
    finish_run();
  end
endmodule